// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Matcher

This block holds a bank of hardware comparators that decide, each cycle, whether the current instruction fetch address should raise a breakpoint event and whether the current data access should raise a watchpoint event. Every comparator has a value register and a control register. Both are loaded through a simple write port. The control fields add three kinds of filtering on top of the address compare: by security state, by privilege level, and optionally by the outcome of a linked context-ID breakpoint.

A debug monitor enable bit gates the whole bank, and so does an external debug-allow input. Breakpoints compare the full fetch address. Watchpoints compare the data address at 8-byte granularity and are qualified by separate load and store enables. When any comparator fires, the block also reports a fault status code. The code depends on whether the long-descriptor translation format is active. All results are registered, so they appear one cycle after the inputs that cause them.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every value and control register is zero, the monitor enable is clear, and bp_match, wp_match, bp_hit, wp_hit and fault_status are all zero.
- R2: A write with cfg_wr_en high loads cfg_wr_data into the register chosen by cfg_wr_kind (0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control, 4 monitor enable taken from data bit 15) at index cfg_wr_idx. The new value governs matching from the next cycle on.
- R3: No comparator reports a match unless the monitor enable bit (written from bit 15) is set and dbg_allow is high.
- R4: Breakpoint i matches when control bit 0 is set, fetch_valid is high and fetch_pc equals its value register exactly. The result appears on bp_match[i] and bp_hit one cycle later.
- R5: Watchpoint i matches when control bit 0 is set, mem_valid is high, and mem_addr equals its value register with address bits [2:0] ignored. A read also needs control bit 3, and a write (mem_write high) needs control bit 4.
- R6: The two-bit security select in control bits [15:14] passes both states when 0. Values 1 and 3 pass only when sec_state is low, and 2 passes only when sec_state is high.
- R7: The privilege filter passes at level 2 or 3 only with control bit 13, at level 1 only with control bit 1, and at level 0 only with control bit 2.
- R8: A watchpoint access with mem_unpriv high is filtered as level 0, whatever cur_el is.
- R9: With control bit 20 set, a comparator also needs its linked breakpoint, whose index is held in control bits [19:16]. That index must lie in the top NUM_CTX breakpoint slots (NUM_BP-NUM_CTX up to NUM_BP-1). The linked breakpoint's control bit 0 must be set and its type field, control bits [23:20], must equal 3.
- R10: A linked context breakpoint passes only while cur_el is 0 or 1 and ctx_id equals the low CTX_W bits of its value register.
- R11: fault_status is 0x222 when any hit is reported and long_desc was high, 0x002 when a hit is reported and long_desc was low, and 0 when no hit is reported.
- R12: Several comparators may match in the same cycle. Each sets its own bit in bp_match or wp_match, and bp_hit and wp_hit are the OR of those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_kind | input | 3 | Register kind selector |
| cfg_wr_idx | input | IDX_W | Comparator index for the write |
| cfg_wr_data | input | ADDR_W | Write data |
| dbg_allow | input | 1 | Debug events otherwise permitted |
| cur_el | input | 2 | Current privilege level |
| sec_state | input | 1 | High when in the secure state |
| long_desc | input | 1 | Long-descriptor format active |
| ctx_id | input | CTX_W | Current context identifier |
| fetch_valid | input | 1 | Instruction fetch address valid |
| fetch_pc | input | ADDR_W | Instruction fetch address |
| mem_valid | input | 1 | Data access valid |
| mem_addr | input | ADDR_W | Data access address |
| mem_write | input | 1 | Data access is a store |
| mem_unpriv | input | 1 | Data access is unprivileged |
| bp_match | output | NUM_BP | Per-breakpoint match, registered |
| wp_match | output | NUM_WP | Per-watchpoint match, registered |
| bp_hit | output | 1 | Any breakpoint matched |
| wp_hit | output | 1 | Any watchpoint matched |
| fault_status | output | 10 | Fault status code for a hit |

## Verification
Directed cases each switch one filter field while the rest pass. This separates the address compare, the security select, each privilege level, the unprivileged override, the load/store enables and every way a link can fail: index out of range, linked comparator disabled, wrong type, context mismatch and elevated level. Overlapping comparators with the same address show that the per-slot vectors are independent. Toggling the monitor bit and dbg_allow shows the global gate. Constrained random traffic then draws fetch, data and context values from the programmed registers, which gives frequent near-misses and hits, and checks every output against a bench model on each step.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

   localparam int CTL_W      = 24;
   localparam int FS_W       = 10;
   localparam int F_EN       = 0;
   localparam int F_PAC_L1   = 1;
   localparam int F_PAC_L0   = 2;
   localparam int F_LD       = 3;
   localparam int F_ST       = 4;
   localparam int F_HMC      = 13;
   localparam int F_SSC_LO   = 14;
   localparam int F_LBN_LO   = 16;
   localparam int F_LINK     = 20;
   localparam int F_TYPE_LO  = 20;
   localparam int MON_EN_BIT = 15;
   localparam int WP_ALIGN   = 3;

   localparam logic [3:0]      CTX_TYPE  = 4'd3;
   localparam logic [FS_W-1:0] FSR_LONG  = 10'h222;
   localparam logic [FS_W-1:0] FSR_SHORT = 10'h002;

   typedef enum logic [2:0] {
      WK_BP_VAL = 3'd0,
      WK_BP_CTL = 3'd1,
      WK_WP_VAL = 3'd2,
      WK_WP_CTL = 3'd3,
      WK_MON    = 3'd4
   } wr_kind_e;

   function automatic logic sec_pass(input logic [1:0] ssc, input logic secure);
      case (ssc)
         2'd0:    return 1'b1;
         2'd2:    return secure;
         default: return !secure;
      endcase
   endfunction

   function automatic logic el_pass(input logic [1:0] el, input logic pac_l1,
                                    input logic pac_l0, input logic hmc);
      case (el)
         2'd0:    return pac_l0;
         2'd1:    return pac_l1;
         default: return hmc;
      endcase
   endfunction

endpackage

// File: rtl/dbgm_regbank.sv
module dbgm_regbank
   import dbgm_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int NUM_WP = 4,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [2:0]                     wr_kind,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [ADDR_W-1:0]              wr_data,
   output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_val,
   output logic [NUM_BP-1:0][CTL_W-1:0]   bp_ctl,
   output logic [NUM_WP-1:0][ADDR_W-1:0]  wp_val,
   output logic [NUM_WP-1:0][CTL_W-1:0]   wp_ctl,
   output logic                           mon_en
);

   logic sel_bp_val, sel_bp_ctl, sel_wp_val, sel_wp_ctl, sel_mon;

   assign sel_bp_val = wr_en && (wr_kind == WK_BP_VAL);
   assign sel_bp_ctl = wr_en && (wr_kind == WK_BP_CTL);
   assign sel_wp_val = wr_en && (wr_kind == WK_WP_VAL);
   assign sel_wp_ctl = wr_en && (wr_kind == WK_WP_CTL);
   assign sel_mon    = wr_en && (wr_kind == WK_MON);

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bp_val[i] <= '0;
            bp_ctl[i] <= '0;
         end else if (wr_idx == IDX_W'(i)) begin
            if (sel_bp_val) bp_val[i] <= wr_data;
            if (sel_bp_ctl) bp_ctl[i] <= wr_data[CTL_W-1:0];
         end
      end
   end

   for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp_val[j] <= '0;
            wp_ctl[j] <= '0;
         end else if (wr_idx == IDX_W'(j)) begin
            if (sel_wp_val) wp_val[j] <= wr_data;
            if (sel_wp_ctl) wp_ctl[j] <= wr_data[CTL_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mon_en <= 1'b0;
      else if (sel_mon) mon_en <= wr_data[MON_EN_BIT];
   end

endmodule

// File: rtl/dbgm_ctx.sv
module dbgm_ctx
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 4,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 32,
   parameter int CTX_W   = 32
) (
   input  logic [NUM_BP-1:0][ADDR_W-1:0] bp_val,
   input  logic [NUM_BP-1:0][CTL_W-1:0]  bp_ctl,
   input  logic [1:0]                    cur_el,
   input  logic [CTX_W-1:0]              ctx_id,
   output logic [NUM_BP-1:0]             ctx_ok
);

   localparam int FIRST_CTX = NUM_BP - NUM_CTX;

   logic low_el;
   logic sink_unused;

   assign low_el      = (cur_el <= 2'd1);
   assign sink_unused = ^{bp_val, bp_ctl};

   for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
      localparam bit IN_RANGE = (i >= FIRST_CTX);
      logic type_ok, id_ok;
      assign type_ok   = bp_ctl[i][F_EN] && (bp_ctl[i][F_TYPE_LO +: 4] == CTX_TYPE);
      assign id_ok     = (bp_val[i][CTX_W-1:0] == ctx_id);
      assign ctx_ok[i] = IN_RANGE && low_el && type_ok && id_ok;
   end

endmodule

// File: rtl/dbgm_cmp.sv
module dbgm_cmp
   import dbgm_pkg::*;
#(
   parameter bit IS_WP  = 1'b0,
   parameter int ADDR_W = 32,
   parameter int NUM_BP = 4
) (
   input  logic [ADDR_W-1:0] val,
   input  logic [CTL_W-1:0]  ctl,
   input  logic [ADDR_W-1:0] addr,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_unpriv,
   input  logic [1:0]        cur_el,
   input  logic              sec_state,
   input  logic [NUM_BP-1:0] ctx_ok,
   output logic              match
);

   logic       addr_hit;
   logic       kind_ok;
   logic [1:0] filt_el;
   logic [3:0] lbn;
   logic       lnk_hit;
   logic       link_ok;
   logic       filt_ok;
   logic       sink_unused;

   assign sink_unused = ^{val, ctl, addr, acc_write, acc_unpriv};

   if (IS_WP) begin : g_wp
      assign addr_hit = (val[ADDR_W-1:WP_ALIGN] == addr[ADDR_W-1:WP_ALIGN]);
      assign kind_ok  = acc_write ? ctl[F_ST] : ctl[F_LD];
      assign filt_el  = acc_unpriv ? 2'd0 : cur_el;
   end else begin : g_bp
      assign addr_hit = (val == addr);
      assign kind_ok  = 1'b1;
      assign filt_el  = cur_el;
   end

   assign lbn = ctl[F_LBN_LO +: 4];

   always_comb begin
      lnk_hit = 1'b0;
      for (int k = 0; k < NUM_BP; k++) begin
         if (lbn == 4'(k)) lnk_hit = ctx_ok[k];
      end
   end

   assign link_ok = !ctl[F_LINK] || lnk_hit;
   assign filt_ok = sec_pass(ctl[F_SSC_LO +: 2], sec_state)
                 && el_pass(filt_el, ctl[F_PAC_L1], ctl[F_PAC_L0], ctl[F_HMC]);
   assign match   = acc_valid && ctl[F_EN] && addr_hit && kind_ok && filt_ok && link_ok;

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbgm_pkg::*;
#(
   parameter int NUM_BP  = 4,
   parameter int NUM_WP  = 4,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 32,
   parameter int CTX_W   = 32,
   localparam int MAX_N  = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
   localparam int IDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [2:0]        cfg_wr_kind,
   input  logic [IDX_W-1:0]  cfg_wr_idx,
   input  logic [ADDR_W-1:0] cfg_wr_data,
   input  logic              dbg_allow,
   input  logic [1:0]        cur_el,
   input  logic              sec_state,
   input  logic              long_desc,
   input  logic [CTX_W-1:0]  ctx_id,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              mem_valid,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_write,
   input  logic              mem_unpriv,
   output logic [NUM_BP-1:0] bp_match,
   output logic [NUM_WP-1:0] wp_match,
   output logic              bp_hit,
   output logic              wp_hit,
   output logic [FS_W-1:0]   fault_status
);

   if (NUM_BP < 1 || NUM_BP > 16) begin : g_bad_bp
      $error("NUM_BP must be 1..16 so a 4-bit link index can reach every slot");
   end
   if (NUM_WP < 1) begin : g_bad_wp
      $error("NUM_WP must be at least 1");
   end
   if (NUM_CTX < 0 || NUM_CTX > NUM_BP) begin : g_bad_ctx
      $error("NUM_CTX must lie in 0..NUM_BP");
   end
   if (CTX_W > ADDR_W) begin : g_bad_ctxw
      $error("CTX_W may not exceed ADDR_W");
   end
   if (ADDR_W <= MON_EN_BIT || ADDR_W < CTL_W || ADDR_W <= WP_ALIGN) begin : g_bad_aw
      $error("ADDR_W too narrow for the control layout");
   end

   logic [NUM_BP-1:0][ADDR_W-1:0] bp_val;
   logic [NUM_BP-1:0][CTL_W-1:0]  bp_ctl;
   logic [NUM_WP-1:0][ADDR_W-1:0] wp_val;
   logic [NUM_WP-1:0][CTL_W-1:0]  wp_ctl;
   logic                          mon_en;
   logic [NUM_BP-1:0]             ctx_ok;
   logic [NUM_BP-1:0]             bp_raw;
   logic [NUM_WP-1:0]             wp_raw;
   logic                          gate;
   logic                          any_raw;

   dbgm_regbank #(
      .NUM_BP (NUM_BP),
      .NUM_WP (NUM_WP),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_kind (cfg_wr_kind),
      .wr_idx  (cfg_wr_idx),
      .wr_data (cfg_wr_data),
      .bp_val  (bp_val),
      .bp_ctl  (bp_ctl),
      .wp_val  (wp_val),
      .wp_ctl  (wp_ctl),
      .mon_en  (mon_en)
   );

   dbgm_ctx #(
      .NUM_BP  (NUM_BP),
      .NUM_CTX (NUM_CTX),
      .ADDR_W  (ADDR_W),
      .CTX_W   (CTX_W)
   ) u_ctx (
      .bp_val (bp_val),
      .bp_ctl (bp_ctl),
      .cur_el (cur_el),
      .ctx_id (ctx_id),
      .ctx_ok (ctx_ok)
   );

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bpc
      dbgm_cmp #(
         .IS_WP  (1'b0),
         .ADDR_W (ADDR_W),
         .NUM_BP (NUM_BP)
      ) u_cmp (
         .val        (bp_val[i]),
         .ctl        (bp_ctl[i]),
         .addr       (fetch_pc),
         .acc_valid  (fetch_valid),
         .acc_write  (1'b0),
         .acc_unpriv (1'b0),
         .cur_el     (cur_el),
         .sec_state  (sec_state),
         .ctx_ok     (ctx_ok),
         .match      (bp_raw[i])
      );
   end

   for (genvar j = 0; j < NUM_WP; j++) begin : g_wpc
      dbgm_cmp #(
         .IS_WP  (1'b1),
         .ADDR_W (ADDR_W),
         .NUM_BP (NUM_BP)
      ) u_cmp (
         .val        (wp_val[j]),
         .ctl        (wp_ctl[j]),
         .addr       (mem_addr),
         .acc_valid  (mem_valid),
         .acc_write  (mem_write),
         .acc_unpriv (mem_unpriv),
         .cur_el     (cur_el),
         .sec_state  (sec_state),
         .ctx_ok     (ctx_ok),
         .match      (wp_raw[j])
      );
   end

   assign gate    = mon_en && dbg_allow;
   assign any_raw = (|bp_raw) || (|wp_raw);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_match     <= '0;
         wp_match     <= '0;
         bp_hit       <= 1'b0;
         wp_hit       <= 1'b0;
         fault_status <= '0;
      end else begin
         bp_match     <= gate ? bp_raw : '0;
         wp_match     <= gate ? wp_raw : '0;
         bp_hit       <= gate && (|bp_raw);
         wp_hit       <= gate && (|wp_raw);
         fault_status <= (gate && any_raw) ? (long_desc ? FSR_LONG : FSR_SHORT) : '0;
      end
   end

endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk
   import dbgm_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            mon_en,
   input logic            dbg_allow,
   input logic            fetch_valid,
   input logic            mem_valid,
   input logic            long_desc,
   input logic            bp_hit,
   input logic            wp_hit,
   input logic [FS_W-1:0] fault_status
);

   // R3
   gate_off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(mon_en) && $past(dbg_allow)) |-> (!bp_hit && !wp_hit));

   // R4
   bp_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> $past(fetch_valid));

   // R5
   wp_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(mem_valid));

   // R11
   fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_hit || wp_hit) |-> (fault_status == ($past(long_desc) ? FSR_LONG : FSR_SHORT)));

   // R11
   fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bp_hit || wp_hit) |-> (fault_status == '0));

endmodule

bind dbg_match_unit dbgm_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mon_en       (mon_en),
   .dbg_allow    (dbg_allow),
   .fetch_valid  (fetch_valid),
   .mem_valid    (mem_valid),
   .long_desc    (long_desc),
   .bp_hit       (bp_hit),
   .wp_hit       (wp_hit),
   .fault_status (fault_status)
);

// File: tb/dbg_match_unit_bench.sv
`timescale 1ns/1ps
module dbg_match_unit_bench;

   localparam int NBP  = 4;
   localparam int NWP  = 4;
   localparam int NCTX = 2;
   localparam int IW   = 2;

   logic          clk;
   logic          rst_n;
   logic          cfg_wr_en;
   logic [2:0]    cfg_wr_kind;
   logic [IW-1:0] cfg_wr_idx;
   logic [31:0]   cfg_wr_data;
   logic          dbg_allow;
   logic [1:0]    cur_el;
   logic          sec_state;
   logic          long_desc;
   logic [31:0]   ctx_id;
   logic          fetch_valid;
   logic [31:0]   fetch_pc;
   logic          mem_valid;
   logic [31:0]   mem_addr;
   logic          mem_write;
   logic          mem_unpriv;
   logic [NBP-1:0] bp_match;
   logic [NWP-1:0] wp_match;
   logic          bp_hit;
   logic          wp_hit;
   logic [9:0]    fault_status;

   logic [31:0] m_bpv [NBP];
   logic [31:0] m_bpc [NBP];
   logic [31:0] m_wpv [NWP];
   logic [31:0] m_wpc [NWP];
   logic        m_mon;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   dbg_match_unit u_dbg_match_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_kind(cfg_wr_kind),
      .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data), .dbg_allow(dbg_allow),
      .cur_el(cur_el), .sec_state(sec_state), .long_desc(long_desc), .ctx_id(ctx_id),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .mem_valid(mem_valid),
      .mem_addr(mem_addr), .mem_write(mem_write), .mem_unpriv(mem_unpriv),
      .bp_match(bp_match), .wp_match(wp_match), .bp_hit(bp_hit), .wp_hit(wp_hit),
      .fault_status(fault_status)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   initial begin
      #3000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=run complete");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic bit e_sec(input logic [1:0] s, input logic sec);
      if (s == 2'd0) return 1'b1;
      if (s == 2'd2) return sec;
      return !sec;
   endfunction

   function automatic bit e_el(input logic [31:0] c, input logic [1:0] el);
      if (el >= 2'd2) return c[13];
      if (el == 2'd1) return c[1];
      return c[2];
   endfunction

   function automatic bit e_ctx(input logic [3:0] l);
      if (int'(l) >= NBP || int'(l) < NBP - NCTX) return 1'b0;
      return m_bpc[l[1:0]][0] && (m_bpc[l[1:0]][23:20] == 4'd3)
             && (cur_el <= 2'd1) && (ctx_id == m_bpv[l[1:0]]);
   endfunction

   function automatic bit e_link(input logic [31:0] c);
      return !c[20] || e_ctx(c[19:16]);
   endfunction

   function automatic logic [NBP-1:0] e_bp();
      logic [NBP-1:0] v = '0;
      for (int i = 0; i < NBP; i++)
         v[i] = m_bpc[i][0] && fetch_valid && (m_bpv[i] == fetch_pc)
                && e_sec(m_bpc[i][15:14], sec_state) && e_el(m_bpc[i], cur_el)
                && e_link(m_bpc[i]);
      return (m_mon && dbg_allow) ? v : '0;
   endfunction

   function automatic logic [NWP-1:0] e_wp();
      logic [NWP-1:0] v = '0;
      logic [1:0] fel = mem_unpriv ? 2'd0 : cur_el;
      for (int j = 0; j < NWP; j++)
         v[j] = m_wpc[j][0] && mem_valid && (m_wpv[j][31:3] == mem_addr[31:3])
                && (mem_write ? m_wpc[j][4] : m_wpc[j][3])
                && e_sec(m_wpc[j][15:14], sec_state) && e_el(m_wpc[j], fel)
                && e_link(m_wpc[j]);
      return (m_mon && dbg_allow) ? v : '0;
   endfunction

   task automatic wr(input logic [2:0] kind, input int idx, input logic [31:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_kind = kind; cfg_wr_idx = IW'(idx); cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      case (kind)
         3'd0: m_bpv[idx] = data;
         3'd1: m_bpc[idx] = {8'h0, data[23:0]};
         3'd2: m_wpv[idx] = data;
         3'd3: m_wpc[idx] = {8'h0, data[23:0]};
         3'd4: m_mon = data[15];
         default: ;
      endcase
   endtask

   task automatic step(input string tag);
      logic [NBP-1:0] eb = e_bp();
      logic [NWP-1:0] ew = e_wp();
      logic [9:0] ef = ((|eb) || (|ew)) ? (long_desc ? 10'h222 : 10'h002) : 10'h0;
      @(negedge clk);
      chk({tag, " bp_match"}, 32'(bp_match), 32'(eb));
      chk({tag, " wp_match"}, 32'(wp_match), 32'(ew));
      chk({tag, " bp_hit"}, 32'(bp_hit), 32'(|eb));
      chk({tag, " wp_hit"}, 32'(wp_hit), 32'(|ew));
      chk({tag, " fault_status"}, 32'(fault_status), 32'(ef));
   endtask

   task automatic fetch(input logic [31:0] pc, input logic [1:0] el, input logic sec);
      fetch_valid = 1'b1; fetch_pc = pc; cur_el = el; sec_state = sec; mem_valid = 1'b0;
   endtask

   task automatic access(input logic [31:0] a, input logic w, input logic up, input logic [1:0] el);
      mem_valid = 1'b1; mem_addr = a; mem_write = w; mem_unpriv = up; cur_el = el;
      fetch_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] r;
      r = $urandom(32'd2024);
      rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_kind = '0; cfg_wr_idx = '0; cfg_wr_data = '0;
      dbg_allow = 1'b0; cur_el = '0; sec_state = 1'b0; long_desc = 1'b0; ctx_id = '0;
      fetch_valid = 1'b0; fetch_pc = '0; mem_valid = 1'b0; mem_addr = '0;
      mem_write = 1'b0; mem_unpriv = 1'b0;
      for (int i = 0; i < NBP; i++) begin m_bpv[i] = '0; m_bpc[i] = '0; end
      for (int j = 0; j < NWP; j++) begin m_wpv[j] = '0; m_wpc[j] = '0; end
      m_mon = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 bp_match", 32'(bp_match), 0);
      chk("R1 wp_match", 32'(wp_match), 0);
      chk("R1 fault_status", 32'(fault_status), 0);
      dbg_allow = 1'b1;
      fetch(32'h0, 2'd1, 1'b0); step("R1 zeroed regs no match");

      // R2 write port, R4 breakpoint compare
      wr(3'd4, 0, 32'h0000_8000);
      wr(3'd0, 0, 32'h0000_1000);
      wr(3'd1, 0, 32'h0000_2007);
      fetch(32'h1000, 2'd1, 1'b0); step("R4 exact pc hit");
      fetch(32'h1004, 2'd1, 1'b0); step("R4 pc miss");
      fetch_valid = 1'b0; fetch_pc = 32'h1000; step("R4 fetch invalid");
      wr(3'd0, 1, 32'h0000_1004);
      wr(3'd1, 1, 32'h0000_2007);
      fetch(32'h1004, 2'd1, 1'b0); step("R2 new write takes effect");
      wr(3'd5, 1, 32'h0);
      fetch(32'h1004, 2'd1, 1'b0); step("R2 unused kind ignored");

      // R3 global gate
      wr(3'd4, 0, 32'h0000_0000);
      fetch(32'h1000, 2'd1, 1'b0); step("R3 monitor bit clear");
      wr(3'd4, 0, 32'h0000_8000);
      dbg_allow = 1'b0; step("R3 dbg_allow low");
      dbg_allow = 1'b1; step("R3 gate open again");

      // R6 security select
      wr(3'd1, 0, 32'h0000_A007);
      fetch(32'h1000, 2'd1, 1'b0); step("R6 ssc2 nonsecure");
      fetch(32'h1000, 2'd1, 1'b1); step("R6 ssc2 secure");
      wr(3'd1, 0, 32'h0000_6007);
      fetch(32'h1000, 2'd1, 1'b0); step("R6 ssc1 nonsecure");
      fetch(32'h1000, 2'd1, 1'b1); step("R6 ssc1 secure");
      wr(3'd1, 0, 32'h0000_E007);
      fetch(32'h1000, 2'd1, 1'b1); step("R6 ssc3 secure");

      // R7 privilege filter
      wr(3'd1, 0, 32'h0000_0003);
      fetch(32'h1000, 2'd1, 1'b0); step("R7 level1 bit1");
      fetch(32'h1000, 2'd0, 1'b0); step("R7 level0 without bit2");
      fetch(32'h1000, 2'd2, 1'b0); step("R7 level2 without bit13");
      wr(3'd1, 0, 32'h0000_0005);
      fetch(32'h1000, 2'd0, 1'b0); step("R7 level0 bit2");
      wr(3'd1, 0, 32'h0000_2001);
      fetch(32'h1000, 2'd3, 1'b0); step("R7 level3 bit13");
      fetch(32'h1000, 2'd2, 1'b0); step("R7 level2 bit13");
      fetch(32'h1000, 2'd1, 1'b0); step("R7 level1 only bit13");

      // R5 watchpoint compare and load/store enables
      wr(3'd2, 0, 32'h0000_2000);
      wr(3'd3, 0, 32'h0000_200F);
      access(32'h2005, 1'b0, 1'b0, 2'd1); step("R5 read in 8-byte granule");
      access(32'h2005, 1'b1, 1'b0, 2'd1); step("R5 write without store bit");
      access(32'h2008, 1'b0, 1'b0, 2'd1); step("R5 next granule");
      wr(3'd3, 0, 32'h0000_2017);
      access(32'h2007, 1'b1, 1'b0, 2'd1); step("R5 write with store bit");
      access(32'h2007, 1'b0, 1'b0, 2'd1); step("R5 read without load bit");

      // R8 unprivileged access filtered as level 0
      wr(3'd3, 0, 32'h0000_000D);
      access(32'h2000, 1'b0, 1'b1, 2'd1); step("R8 unpriv at level1");
      access(32'h2000, 1'b0, 1'b0, 2'd1); step("R8 priv at level1");

      // R9 R10 linked context breakpoint
      wr(3'd0, 3, 32'hCAFE_0001);
      wr(3'd1, 3, 32'h0030_0001);
      wr(3'd0, 1, 32'h0000_1100);
      wr(3'd1, 1, 32'h0013_2007);
      ctx_id = 32'hCAFE_0001;
      fetch(32'h1100, 2'd1, 1'b0); step("R10 context equal level1");
      ctx_id = 32'hCAFE_0002; step("R10 context differs");
      ctx_id = 32'hCAFE_0001;
      fetch(32'h1100, 2'd2, 1'b0); step("R10 level2 blocks link");
      wr(3'd1, 1, 32'h0011_2007);
      fetch(32'h1100, 2'd1, 1'b0); step("R9 link index below range");
      wr(3'd1, 1, 32'h0015_2007); step("R9 link index above range");
      wr(3'd1, 1, 32'h0013_2007);
      wr(3'd1, 3, 32'h0030_0000); step("R9 linked slot disabled");
      wr(3'd1, 3, 32'h0050_0001); step("R9 linked type not 3");
      wr(3'd1, 3, 32'h0030_0001); step("R9 link restored");
      wr(3'd3, 1, 32'h0013_0009);
      wr(3'd2, 1, 32'h0000_3000);
      access(32'h3003, 1'b0, 1'b1, 2'd1); step("R9 linked watchpoint");

      // R11 fault code and R12 multiple matches
      wr(3'd0, 2, 32'h0000_1000);
      wr(3'd1, 2, 32'h0000_2007);
      wr(3'd1, 0, 32'h0000_2007);
      long_desc = 1'b1;
      fetch(32'h1000, 2'd1, 1'b0); step("R12 two breakpoints R11 long");
      long_desc = 1'b0; step("R11 short code");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         if (it % 8 == 0) begin
            int k = $urandom_range(0, 4);
            int ix = $urandom_range(0, 3);
            logic [31:0] d = $urandom;
            logic [31:0] pool [4] = '{32'h1000, 32'h1100, 32'h2000, 32'hCAFE_0001};
            if (k == 0 || k == 2) d = pool[$urandom_range(0, 3)];
            if (k == 1 || k == 3) begin
               d[0] = ($urandom_range(0, 3) != 0);
               if ($urandom_range(0, 2) == 0) d[23:20] = 4'd3;
            end
            if (k == 4) d[15] = ($urandom_range(0, 5) != 0);
            wr(3'(k), ix, d);
         end
         fetch_valid = 1'($urandom_range(0, 1));
         fetch_pc    = ($urandom_range(0, 3) != 0) ? m_bpv[$urandom_range(0, 3)] : $urandom;
         mem_valid   = 1'($urandom_range(0, 1));
         mem_addr    = ($urandom_range(0, 3) != 0) ? (m_wpv[$urandom_range(0, 3)] ^ 32'($urandom_range(0, 7)))
                                                    : $urandom;
         mem_write   = 1'($urandom_range(0, 1));
         mem_unpriv  = 1'($urandom_range(0, 1));
         cur_el      = 2'($urandom_range(0, 3));
         sec_state   = 1'($urandom_range(0, 1));
         long_desc   = 1'($urandom_range(0, 1));
         dbg_allow   = ($urandom_range(0, 7) != 0);
         ctx_id      = ($urandom_range(0, 1) != 0) ? m_bpv[$urandom_range(2, 3)] : $urandom;
         step("R4-R12 random mix");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule